// File: doc/BRIEF.md
# Branch Shadow Resolution Unit

This block keeps track of instructions issued speculatively while one conditional branch is still open. When the issue stage sends an instruction, it marks it as belonging to the success path, to the fail path, or to neither. Each marked instruction takes one of a fixed pool of shadow slots. Instructions on the two paths may be issued interleaved, so both groups are in flight at the same time.

When the branch condition is presented on the resolve port, the unit compares the two operands as unsigned values, as the branch opcode selects, and registers a 2-bit direction. In the next cycle every occupied slot gives exactly one pulse. A slot on the path that was taken gets a release (go) pulse. A slot on the other path gets a cancel pulse. All slots are then freed and the direction goes back to unresolved, so the next branch can be tracked.

Top module: `branch_shadow_unit`

## Requirements
- R1: After reset the direction reads 0, no slot is occupied, and stall, error, go and cancel are all low.
- R2: A resolve request with opcode bit 2 set is a branch. Opcode 4 tests operand A >= operand B, 5 tests A < B, 6 tests A == B and 7 tests A != B, all unsigned. A true test sets the direction to 1 (success) and a false test sets it to 2 (fail), starting in the cycle after the request. The value 3 never appears.
- R3: A resolve request whose opcode has bit 2 clear (codes 0 to 3) is ignored. The direction stays 0 and the occupied slots remain held.
- R4: When the direction is 1, each occupied slot tagged for success pulses go and each occupied slot tagged for fail pulses cancel, in that same cycle.
- R5: When the direction is 2, each occupied slot tagged for fail pulses go and each occupied slot tagged for success pulses cancel.
- R6: An issue with neither flag set takes no slot and never produces a go or cancel pulse.
- R7: An issue with both flags set raises the error output in that cycle and takes no slot.
- R8: There are 8 slots. The stall output is high while all slots are occupied or while the direction is nonzero, and an issue presented while stall is high is not accepted.
- R9: A nonzero direction lasts exactly one cycle. All slots are freed and the direction returns to 0 after that cycle, and a second resolve request during that cycle is ignored.
- R10: An accepted issue takes the lowest-numbered free slot, and that slot's tag output shows the issue tag while the slot is occupied.
- R11: No slot ever pulses go and cancel together, and go and cancel stay low while the direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | An instruction is presented for issue |
| iss_tag_i | input | TAGW | Identifier of the issuing instruction |
| iss_on_succ_i | input | 1 | Instruction depends on the branch succeeding |
| iss_on_fail_i | input | 1 | Instruction depends on the branch failing |
| iss_stall_o | output | 1 | Issue cannot be accepted this cycle |
| iss_err_o | output | 1 | Both shadow flags were set on a valid issue |
| rsv_valid_i | input | 1 | Branch resolve request |
| rsv_op_i | input | 3 | Opcode; bit 2 marks a branch |
| rsv_a_i | input | DW | Operand A |
| rsv_b_i | input | DW | Operand B |
| dir_o | output | 2 | 0 unresolved, 1 success, 2 fail |
| go_o | output | NSLOT | Per-slot release pulse |
| cancel_o | output | NSLOT | Per-slot cancel pulse |
| slot_tag_o | output | NSLOT*TAGW | Stored tag of each slot, slot 0 in the low bits |

## Verification
Some properties are checked by assertions on every cycle. Go and cancel are exclusive. They are silent while the direction is 0. When the direction is nonzero, they cover every occupied slot. The direction is never 3, it lasts one cycle and it leaves all slots empty. A full pool always stalls, a non-branch request never resolves, and a double-flagged issue changes no slot. Other behaviour can only be shown by the bench's scenarios, which predict the outcome from a model: which path each slot ends on, the result of each comparison opcode at its boundaries, lowest-free allocation with the matching tags, and a second resolve request being dropped.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
   localparam int OP_W   = 3;
   localparam int BR_BIT = 2;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_SUCC = 2'd1,
      DIR_FAIL = 2'd2
   } dir_e;

   typedef enum logic [1:0] {
      CMP_GE = 2'd0,
      CMP_LT = 2'd1,
      CMP_EQ = 2'd2,
      CMP_NE = 2'd3
   } cmp_e;
endpackage

// File: rtl/bsu_cond.sv
module bsu_cond
   import bsu_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [DW-1:0]   a_i,
   input  logic [DW-1:0]   b_i,
   output logic            is_br_o,
   output logic            taken_o
);
   if (DW < 1) begin : g_bad_dw
      $error("bsu_cond: DW must be at least 1");
   end

   cmp_e kind;
   assign kind    = cmp_e'(op_i[1:0]);
   assign is_br_o = op_i[BR_BIT];

   always_comb begin
      unique case (kind)
         CMP_GE:  taken_o = (a_i >= b_i);
         CMP_LT:  taken_o = (a_i <  b_i);
         CMP_EQ:  taken_o = (a_i == b_i);
         CMP_NE:  taken_o = (a_i != b_i);
         default: taken_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/bsu_pick.sv
module bsu_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] free_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   if (N < 1) begin : g_bad_n
      $error("bsu_pick: N must be at least 1");
   end

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant_o[i]  = free_i[i] & ~seen[i];
      assign seen[i+1]   = seen[i] | free_i[i];
   end

   assign any_o = seen[N];
endmodule

// File: rtl/bsu_slots.sv
module bsu_slots #(
   parameter int N             = 8,
   parameter int TAGW          = 4,
   parameter bit RESET_PAYLOAD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    alloc_i,
   input  logic            alloc_succ_i,
   input  logic [TAGW-1:0] alloc_tag_i,
   input  logic            clr_i,
   output logic [N-1:0]    occ_o,
   output logic [N-1:0]    succ_o,
   output logic [N*TAGW-1:0] tags_o
);
   if (TAGW < 1) begin : g_bad_tagw
      $error("bsu_slots: TAGW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      occ_o <= '0;
      else if (clr_i)  occ_o <= '0;
      else             occ_o <= occ_o | alloc_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      if (RESET_PAYLOAD) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               succ_o[i]                 <= 1'b0;
               tags_o[i*TAGW +: TAGW]    <= '0;
            end else if (alloc_i[i]) begin
               succ_o[i]                 <= alloc_succ_i;
               tags_o[i*TAGW +: TAGW]    <= alloc_tag_i;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (alloc_i[i]) begin
               succ_o[i]                 <= alloc_succ_i;
               tags_o[i*TAGW +: TAGW]    <= alloc_tag_i;
            end
         end
      end
   end
endmodule

// File: rtl/branch_shadow_unit.sv
module branch_shadow_unit
   import bsu_pkg::*;
#(
   parameter int NSLOT         = 8,
   parameter int TAGW          = 4,
   parameter int DW            = 16,
   parameter bit RESET_PAYLOAD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  iss_valid_i,
   input  logic [TAGW-1:0]       iss_tag_i,
   input  logic                  iss_on_succ_i,
   input  logic                  iss_on_fail_i,
   output logic                  iss_stall_o,
   output logic                  iss_err_o,
   input  logic                  rsv_valid_i,
   input  logic [OP_W-1:0]       rsv_op_i,
   input  logic [DW-1:0]         rsv_a_i,
   input  logic [DW-1:0]         rsv_b_i,
   output logic [1:0]            dir_o,
   output logic [NSLOT-1:0]      go_o,
   output logic [NSLOT-1:0]      cancel_o,
   output logic [NSLOT*TAGW-1:0] slot_tag_o
);
   if (NSLOT < 1) begin : g_bad_nslot
      $error("branch_shadow_unit: NSLOT must be at least 1");
   end

   logic [NSLOT-1:0] occ, succ_side, grant, alloc, keep;
   logic             any_free, is_br, taken, resolving, accept;
   dir_e             dir_q;

   bsu_cond #(.DW(DW)) u_cond (
      .op_i    (rsv_op_i),
      .a_i     (rsv_a_i),
      .b_i     (rsv_b_i),
      .is_br_o (is_br),
      .taken_o (taken)
   );

   bsu_pick #(.N(NSLOT)) u_pick (
      .free_i  (~occ),
      .grant_o (grant),
      .any_o   (any_free)
   );

   assign resolving   = (dir_q != DIR_NONE);
   assign iss_err_o   = iss_valid_i & iss_on_succ_i & iss_on_fail_i;
   assign iss_stall_o = ~any_free | resolving;
   assign accept      = iss_valid_i & (iss_on_succ_i ^ iss_on_fail_i) & ~iss_stall_o;
   assign alloc       = accept ? grant : '0;

   bsu_slots #(.N(NSLOT), .TAGW(TAGW), .RESET_PAYLOAD(RESET_PAYLOAD)) u_slots (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc),
      .alloc_succ_i (iss_on_succ_i),
      .alloc_tag_i  (iss_tag_i),
      .clr_i        (resolving),
      .occ_o        (occ),
      .succ_o       (succ_side),
      .tags_o       (slot_tag_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    dir_q <= DIR_NONE;
      else if (resolving)            dir_q <= DIR_NONE;
      else if (rsv_valid_i && is_br) dir_q <= taken ? DIR_SUCC : DIR_FAIL;
   end

   assign keep     = (dir_q == DIR_SUCC) ? succ_side : ~succ_side;
   assign go_o     = resolving ? (occ & keep)  : '0;
   assign cancel_o = resolving ? (occ & ~keep) : '0;
   assign dir_o    = dir_q;
endmodule

// File: rtl/bsu_chk.sv
module bsu_chk
   import bsu_pkg::*;
#(
   parameter int NSLOT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid_i,
   input logic             iss_on_succ_i,
   input logic             iss_on_fail_i,
   input logic             iss_err_o,
   input logic             iss_stall_o,
   input logic             rsv_valid_i,
   input logic [OP_W-1:0]  rsv_op_i,
   input logic [1:0]       dir_o,
   input logic [NSLOT-1:0] go_o,
   input logic [NSLOT-1:0] cancel_o,
   input logic [NSLOT-1:0] occ
);
   // R11
   go_cancel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o & cancel_o) == '0);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o == 2'd0) |-> (go_o == '0 && cancel_o == '0));
   // R2
   dir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_o != 2'd3);
   // R4
   release_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o != 2'd0) |-> ((go_o | cancel_o) == occ));
   // R9
   dir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o != 2'd0) |=> (dir_o == 2'd0 && occ == '0));
   // R8
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&occ) |-> iss_stall_o);
   // R3
   nonbranch_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o == 2'd0 && rsv_valid_i && !rsv_op_i[BR_BIT]) |=> (dir_o == 2'd0));
   // R7
   both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o == 2'd0 && iss_valid_i && iss_on_succ_i && iss_on_fail_i)
      |-> iss_err_o ##1 $stable(occ));
endmodule

bind branch_shadow_unit bsu_chk #(.NSLOT(NSLOT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .iss_valid_i   (iss_valid_i),
   .iss_on_succ_i (iss_on_succ_i),
   .iss_on_fail_i (iss_on_fail_i),
   .iss_err_o     (iss_err_o),
   .iss_stall_o   (iss_stall_o),
   .rsv_valid_i   (rsv_valid_i),
   .rsv_op_i      (rsv_op_i),
   .dir_o         (dir_o),
   .go_o          (go_o),
   .cancel_o      (cancel_o),
   .occ           (occ)
);

// File: tb/branch_shadow_unit_test.sv
`timescale 1ns/1ps
module branch_shadow_unit_test;
   localparam int NSLOT = 8;
   localparam int TAGW  = 4;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_valid_i = 1'b0, iss_on_succ_i = 1'b0, iss_on_fail_i = 1'b0;
   logic [TAGW-1:0] iss_tag_i = '0;
   logic iss_stall_o, iss_err_o;
   logic rsv_valid_i = 1'b0;
   logic [2:0] rsv_op_i = '0;
   logic [DW-1:0] rsv_a_i = '0, rsv_b_i = '0;
   logic [1:0] dir_o;
   logic [NSLOT-1:0] go_o, cancel_o;
   logic [NSLOT*TAGW-1:0] slot_tag_o;

   always #4 clk = ~clk;

   branch_shadow_unit #(.NSLOT(NSLOT), .TAGW(TAGW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid_i(iss_valid_i), .iss_tag_i(iss_tag_i),
      .iss_on_succ_i(iss_on_succ_i), .iss_on_fail_i(iss_on_fail_i),
      .iss_stall_o(iss_stall_o), .iss_err_o(iss_err_o),
      .rsv_valid_i(rsv_valid_i), .rsv_op_i(rsv_op_i),
      .rsv_a_i(rsv_a_i), .rsv_b_i(rsv_b_i),
      .dir_o(dir_o), .go_o(go_o), .cancel_o(cancel_o), .slot_tag_o(slot_tag_o)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   int m_cnt = 0;
   logic m_succ [NSLOT];
   logic [TAGW-1:0] m_tag [NSLOT];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit cond_true(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      case (op[1:0])
         2'd0: return a >= b;
         2'd1: return a < b;
         2'd2: return a == b;
         default: return a != b;
      endcase
   endfunction

   // one issue cycle; checks combinational outputs, updates the model
   task automatic do_issue(input bit v, input bit s, input bit f, input logic [TAGW-1:0] tag);
      @(negedge clk);
      iss_valid_i = v; iss_on_succ_i = s; iss_on_fail_i = f; iss_tag_i = tag;
      rsv_valid_i = 1'b0;
      #1;
      chk(iss_err_o == (v & s & f), "R7 err", 32'(iss_err_o), 32'(v & s & f));
      chk(iss_stall_o == (m_cnt == NSLOT), "R8 stall", 32'(iss_stall_o), 32'(m_cnt == NSLOT));
      chk(go_o == '0 && cancel_o == '0, "R11 idle quiet", 32'({go_o, cancel_o}), 32'd0);
      if (v && (s ^ f) && m_cnt < NSLOT) begin
         m_succ[m_cnt] = s;
         m_tag[m_cnt]  = tag;
         m_cnt++;
      end
   endtask

   task automatic do_resolve(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b, input bit hold);
      logic [1:0] exp_dir;
      @(negedge clk);
      iss_valid_i = 1'b0; iss_on_succ_i = 1'b0; iss_on_fail_i = 1'b0;
      rsv_valid_i = 1'b1; rsv_op_i = op; rsv_a_i = a; rsv_b_i = b;
      #1;
      chk(dir_o == 2'd0, "R2 dir before resolve", 32'(dir_o), 32'd0);
      // R10: tags of occupied slots, lowest-first fill
      for (int i = 0; i < m_cnt; i++)
         chk(slot_tag_o[i*TAGW +: TAGW] == m_tag[i], "R10 slot tag",
             32'(slot_tag_o[i*TAGW +: TAGW]), 32'(m_tag[i]));
      @(negedge clk);
      if (!hold) rsv_valid_i = 1'b0;
      #1;
      if (!op[2]) begin
         chk(dir_o == 2'd0, "R3 non-branch ignored", 32'(dir_o), 32'd0);
         chk(go_o == '0 && cancel_o == '0, "R3 no release", 32'({go_o, cancel_o}), 32'd0);
         chk(iss_stall_o == (m_cnt == NSLOT), "R3 slots held", 32'(iss_stall_o), 32'(m_cnt == NSLOT));
         rsv_valid_i = 1'b0;
         return;
      end
      exp_dir = cond_true(op, a, b) ? 2'd1 : 2'd2;
      chk(dir_o == exp_dir, "R2 direction", 32'(dir_o), 32'(exp_dir));
      chk(iss_stall_o == 1'b1, "R8 stall while resolved", 32'(iss_stall_o), 32'd1);
      for (int i = 0; i < NSLOT; i++) begin
         logic eg, ec;
         eg = (i < m_cnt) && (m_succ[i] == (exp_dir == 2'd1));
         ec = (i < m_cnt) && !eg;
         chk(go_o[i] == eg && cancel_o[i] == ec, exp_dir == 2'd1 ? "R4 go/cancel" : "R5 go/cancel",
             32'({go_o[i], cancel_o[i]}), 32'({eg, ec}));
      end
      @(negedge clk);
      rsv_valid_i = 1'b0;
      #1;
      chk(dir_o == 2'd0, "R9 direction back to 0", 32'(dir_o), 32'd0);
      chk(go_o == '0 && cancel_o == '0, "R9 pulse ended", 32'({go_o, cancel_o}), 32'd0);
      chk(iss_stall_o == 1'b0, "R9 slots freed", 32'(iss_stall_o), 32'd0);
      m_cnt = 0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(dir_o == 2'd0, "R1 dir", 32'(dir_o), 32'd0);
      chk(go_o == '0 && cancel_o == '0, "R1 go/cancel", 32'({go_o, cancel_o}), 32'd0);
      chk(iss_stall_o == 1'b0 && iss_err_o == 1'b0, "R1 stall/err", 32'({iss_stall_o, iss_err_o}), 32'd0);
      rst_n = 1'b1;

      // interleaved success/fail paths, branch taken (R4)
      for (int i = 0; i < 4; i++) begin
         do_issue(1, 1, 0, 4'(2*i));
         do_issue(1, 0, 1, 4'(2*i+1));
      end
      do_resolve(3'd6, 16'h1234, 16'h1234, 0);

      // R6 untagged, R7 both flags, then a fail outcome (R5)
      do_issue(1, 0, 0, 4'hA);
      do_issue(1, 1, 1, 4'hB);
      do_issue(1, 1, 0, 4'hC);
      do_issue(1, 0, 1, 4'hD);
      do_resolve(3'd5, 16'h0005, 16'h0005, 0);

      // R8 fill all slots, extra issue stalls
      for (int i = 0; i < NSLOT; i++) do_issue(1, i[0], !i[0], 4'(i));
      do_issue(1, 1, 0, 4'hF);
      // R3 non-branch opcode ignored
      do_resolve(3'd2, 16'h0001, 16'h0000, 0);
      // R9 second request held during the resolved cycle is ignored
      do_resolve(3'd4, 16'h0000, 16'hFFFF, 1);
      // R2 boundaries of each compare
      do_issue(1, 1, 0, 4'h1);
      do_resolve(3'd4, 16'h8000, 16'h8000, 0);
      do_resolve(3'd7, 16'h0001, 16'h0001, 0);
      do_resolve(3'd5, 16'h7FFF, 16'h8000, 0);

      // random rounds
      for (int r = 0; r < 60; r++) begin
         int n;
         n = $urandom_range(0, 11);
         for (int k = 0; k < n; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            do_issue(sel != 0, sel >= 2 && sel <= 5 || sel == 1, sel >= 6 || sel == 1, 4'($urandom()));
         end
         if ($urandom_range(0, 5) == 0)
            do_resolve(3'($urandom_range(0, 3)), 16'($urandom()), 16'($urandom()), 0);
         do_resolve(3'($urandom_range(4, 7)), 16'($urandom_range(0, 3)), 16'($urandom_range(0, 3)),
                    $urandom_range(0, 3) == 0);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule